// File: doc/BRIEF.md
# Converter Conversion Sequencer

This block is the digital front end of a 10-bit successive-approximation converter. Software reaches it through a byte-wide register bus with four addresses: a selection register, a control/status register and the two bytes of the result. The block times each conversion in converter-clock ticks. A programmable divider derives those ticks from the system clock. The block hands the channel and reference chosen for the running conversion to the analog side, and it captures the sample value from a plain input port when the conversion ends.

A conversion is started by software. It then runs once, or in free-running mode it restarts back to back. When it ends, a completion flag is raised, and an interrupt request follows if it is enabled. The first conversion after the converter is switched on runs a longer initialisation sequence. Clearing the enable bit aborts a conversion in progress. A low-byte read of the result holds the matching high byte, so the two reads always give one consistent result.

Top module: `sar_ctrl_top`

## Requirements
- R1: After reset every register bit reads zero, `irq` is low and `conv_chan`/`conv_ref` are zero. Address 0 is the selection register: bits 7:6 reference, bit 5 left-justify, bits 3:0 channel. Bit 4 of address 0 always reads zero, even after a one is written to it.
- R2: The first conversion started after the enable bit goes from zero to one lasts 25 converter ticks. This includes a start written in the same write that sets enable. Every later conversion lasts 13 ticks.
- R3: Address 1 is the control register: bit 7 enable, bit 6 start/busy, bit 5 free-run, bit 4 flag, bit 3 interrupt enable, bits 2:0 divider select. A select value s gives one tick every 2^max(s,1) system cycles. The divider restarts at each start from idle, so a conversion of L ticks keeps busy at one for exactly L·2^max(s,1) cycles after the write edge.
- R4: Bit 6 of address 1 reads one while a conversion runs. Writing zero to it has no effect. A start written while a conversion is running neither restarts nor lengthens it.
- R5: The flag sets in the cycle the result is updated. Writing one to bit 4 of address 1 clears it, and so does a pulse on `irq_ack`. A completion in the same cycle as a clear wins.
- R6: `sample_in` is captured on the final cycle of a conversion. Address 2 returns the low byte of the 16-bit result pair and address 3 returns the high byte.
- R7: `irq` is high exactly when the flag, the interrupt enable and `gie` are all one.
- R8: `conv_chan`/`conv_ref` take the channel and reference from the selection register when a conversion starts. They hold those values until the next conversion starts, even if the register is rewritten in between.
- R9: The left-justify bit changes the result bytes at once, even during a conversion. When it is set, the 10-bit value sits in bits 15:6 of the pair. When it is clear, the value sits in bits 9:0.
- R10: Writing zero to the enable bit during a conversion stops it at once. No result is stored and the flag stays clear.
- R11: In free-running mode one start gives back-to-back conversions, each of which updates the result. Clearing the free-run bit lets the current conversion finish and then the block goes idle.
- R12: A read of address 2 holds the value that address 3 returns until address 3 is read. A result that arrives between the two reads is not shown in the high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (drives the result-hold side effect) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| sample_in | input | 10 | Sample value from the analog side |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| irq | output | 1 | Interrupt request |
| conv_chan | output | 4 | Channel used by the current conversion |
| conv_ref | output | 2 | Reference used by the current conversion |

## Verification
The assertions check on every cycle the rules that link neighbouring pieces of logic: the interrupt gating, the held channel and reference between conversion starts, busy rising after a start from idle and falling after an abort, the flag rising only on a completion, and the zero read-back of the reserved selection bit. Only the bench scenarios can show the exact conversion lengths in system cycles (25 against 13 ticks, across the divider settings). The same holds for the captured and justified result bytes, the free-run chain and its orderly stop, and the high byte held between the two reads of a result.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;

    localparam int RES_W     = 10;
    localparam int PAIR_W    = 16;
    localparam int CHAN_W    = 4;
    localparam int REF_W     = 2;
    localparam int PS_W      = 3;
    localparam int FIRST_LEN = 25;
    localparam int NORM_LEN  = 13;
    localparam int PAD_W     = PAIR_W - RES_W;

    typedef enum logic [1:0] {
        A_SEL    = 2'd0,
        A_CTRL   = 2'd1,
        A_RES_LO = 2'd2,
        A_RES_HI = 2'd3
    } reg_addr_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic [REF_W-1:0]  refsel;
        logic              left;
        logic [CHAN_W-1:0] chan;
    } sel_reg_t;

    typedef struct packed {
        logic            en;
        logic            free;
        logic            ie;
        logic [PS_W-1:0] ps;
    } ctrl_reg_t;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic [REF_W-1:0]  refsel;
    } conv_cfg_t;

    // Place a raw sample inside the 16-bit result pair.
    function automatic logic [PAIR_W-1:0] place_result(input logic [RES_W-1:0] v,
                                                       input logic left);
        if (left)
            return {v, {PAD_W{1'b0}}};
        else
            return {{PAD_W{1'b0}}, v};
    endfunction

endpackage

// File: rtl/sar_ctrl_prescale.sv
module sar_ctrl_prescale
    import sar_ctrl_pkg::*;
#(
    parameter int SEL_W = PS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CW = (1 << SEL_W) - 1;

    logic [CW-1:0]    cnt;
    logic [CW-1:0]    mask;
    logic [SEL_W-1:0] sh;

    // A select of zero divides by two, like a select of one.
    always_comb begin
        sh   = (sel == '0) ? SEL_W'(1) : sel;
        mask = CW'((64'd1 << sh) - 64'd1);
    end

    // The divider restarts whenever no conversion is running.
    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end

    assign tick = run && ((cnt & mask) == mask);

endmodule

// File: rtl/sar_ctrl_seq.sv
module sar_ctrl_seq
    import sar_ctrl_pkg::*;
#(
    parameter int FIRST_TICKS = FIRST_LEN,
    parameter int NORM_TICKS  = NORM_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic start_req,
    input  logic abort,
    input  logic tick,
    input  logic free,
    output logic busy,
    output logic done,
    output logic launch
);
    localparam int LW = $clog2(FIRST_TICKS);
    localparam logic [LW-1:0] LAST_FIRST = LW'(FIRST_TICKS - 1);
    localparam logic [LW-1:0] LAST_NORM  = LW'(NORM_TICKS - 1);

    seq_state_e    state;
    logic [LW-1:0] cnt;
    logic          first_q;
    logic          inited;
    logic [LW-1:0] last;
    logic          at_end;

    always_comb begin
        last   = first_q ? LAST_FIRST : LAST_NORM;
        at_end = (state == ST_RUN) && tick && (cnt == last);
        done   = at_end && !abort;
        launch = ((state == ST_IDLE) && start_req && !abort) || (done && free);
        busy   = (state == ST_RUN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            first_q <= 1'b0;
            inited  <= 1'b0;
        end else if (abort) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            first_q <= 1'b0;
            inited  <= 1'b0;
        end else if (state == ST_IDLE) begin
            if (start_req) begin
                state   <= ST_RUN;
                cnt     <= '0;
                first_q <= !inited;
                inited  <= 1'b1;
            end
        end else if (tick) begin
            if (cnt == last) begin
                cnt     <= '0;
                first_q <= 1'b0;
                if (!free)
                    state <= ST_IDLE;
            end else begin
                cnt <= cnt + LW'(1);
            end
        end
    end

endmodule

// File: rtl/sar_ctrl_result.sv
module sar_ctrl_result
    import sar_ctrl_pkg::*;
#(
    parameter int VAL_W = RES_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic [VAL_W-1:0] sample,
    input  logic             left,
    input  logic             rd_lo,
    input  logic             rd_hi,
    output logic [7:0]       lo_byte,
    output logic [7:0]       hi_byte
);
    logic [VAL_W-1:0]  res;
    logic [VAL_W-1:0]  snap;
    logic              frozen;
    logic [PAIR_W-1:0] live_pair;
    logic [PAIR_W-1:0] held_pair;

    always_ff @(posedge clk) begin
        if (rst) begin
            res    <= '0;
            snap   <= '0;
            frozen <= 1'b0;
        end else begin
            if (capture)
                res <= sample;
            if (rd_lo) begin
                snap   <= res;
                frozen <= 1'b1;
            end else if (rd_hi) begin
                frozen <= 1'b0;
            end
        end
    end

    // Justification is applied at read time, so it acts immediately.
    always_comb begin
        live_pair = place_result(res, left);
        held_pair = place_result(frozen ? snap : res, left);
        lo_byte   = live_pair[7:0];
        hi_byte   = held_pair[15:8];
    end

endmodule

// File: rtl/sar_ctrl_top.sv
module sar_ctrl_top
    import sar_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [RES_W-1:0]  sample_in,
    input  logic              gie,
    input  logic              irq_ack,
    output logic              irq,
    output logic [CHAN_W-1:0] conv_chan,
    output logic [REF_W-1:0]  conv_ref
);
    sel_reg_t  sel_q;
    ctrl_reg_t ctrl_q;
    conv_cfg_t cfg_q;
    logic      flag_q;

    logic wr_sel, wr_ctl, rd_lo, rd_hi;
    logic start_req, abort;
    logic tick, seq_busy, seq_done, seq_launch;
    logic [7:0] lo_byte, hi_byte;

    always_comb begin
        wr_sel    = bus_wr && (reg_addr_e'(bus_addr) == A_SEL);
        wr_ctl    = bus_wr && (reg_addr_e'(bus_addr) == A_CTRL);
        rd_lo     = bus_rd && (reg_addr_e'(bus_addr) == A_RES_LO);
        rd_hi     = bus_rd && (reg_addr_e'(bus_addr) == A_RES_HI);
        start_req = wr_ctl && bus_wdata[7] && bus_wdata[6];
        abort     = wr_ctl && !bus_wdata[7];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            ctrl_q <= '0;
            cfg_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (wr_sel) begin
                sel_q.refsel <= bus_wdata[7:6];
                sel_q.left   <= bus_wdata[5];
                sel_q.chan   <= bus_wdata[3:0];
            end
            if (wr_ctl) begin
                ctrl_q.en   <= bus_wdata[7];
                ctrl_q.free <= bus_wdata[5];
                ctrl_q.ie   <= bus_wdata[3];
                ctrl_q.ps   <= bus_wdata[2:0];
            end
            if (seq_launch) begin
                cfg_q.chan   <= sel_q.chan;
                cfg_q.refsel <= sel_q.refsel;
            end
            if (seq_done)
                flag_q <= 1'b1;
            else if ((wr_ctl && bus_wdata[4]) || irq_ack)
                flag_q <= 1'b0;
        end
    end

    sar_ctrl_prescale #(.SEL_W(PS_W)) prescale_i (
        .clk  (clk),
        .rst  (rst),
        .run  (seq_busy),
        .sel  (ctrl_q.ps),
        .tick (tick)
    );

    sar_ctrl_seq #(.FIRST_TICKS(FIRST_LEN), .NORM_TICKS(NORM_LEN)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .abort     (abort),
        .tick      (tick),
        .free      (ctrl_q.free),
        .busy      (seq_busy),
        .done      (seq_done),
        .launch    (seq_launch)
    );

    sar_ctrl_result #(.VAL_W(RES_W)) result_i (
        .clk     (clk),
        .rst     (rst),
        .capture (seq_done),
        .sample  (sample_in),
        .left    (sel_q.left),
        .rd_lo   (rd_lo),
        .rd_hi   (rd_hi),
        .lo_byte (lo_byte),
        .hi_byte (hi_byte)
    );

    always_comb begin
        unique case (reg_addr_e'(bus_addr))
            A_SEL:    bus_rdata = {sel_q.refsel, sel_q.left, 1'b0, sel_q.chan};
            A_CTRL:   bus_rdata = {ctrl_q.en, seq_busy, ctrl_q.free, flag_q,
                                   ctrl_q.ie, ctrl_q.ps};
            A_RES_LO: bus_rdata = lo_byte;
            default:  bus_rdata = hi_byte;
        endcase
    end

    assign irq       = flag_q && ctrl_q.ie && gie;
    assign conv_chan = cfg_q.chan;
    assign conv_ref  = cfg_q.refsel;

endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
    parameter int CW = 4,
    parameter int RW = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          irq,
    input logic          gie,
    input logic          ie,
    input logic          flag,
    input logic          done,
    input logic          busy,
    input logic          start_req,
    input logic          abort,
    input logic          launch,
    input logic [CW-1:0] conv_chan,
    input logic [RW-1:0] conv_ref,
    input logic [1:0]    bus_addr,
    input logic [7:0]    bus_rdata
);
    assert_irq_gate_R7: assert property (@(posedge clk) disable iff (rst)
        irq |-> (gie && ie && flag));

    assert_cfg_held_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(launch) |-> ($stable(conv_chan) && $stable(conv_ref)));

    assert_flag_only_on_done_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(done));

    assert_flag_after_done_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> flag);

    assert_busy_after_start_R4: assert property (@(posedge clk) disable iff (rst)
        (start_req && !busy) |=> busy);

    assert_abort_idles_R10: assert property (@(posedge clk) disable iff (rst)
        abort |=> !busy);

    assert_sel_bit4_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd0) |-> (bus_rdata[4] == 1'b0));

endmodule

bind sar_ctrl_top sar_ctrl_chk #(.CW(4), .RW(2)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .irq       (irq),
    .gie       (gie),
    .ie        (ctrl_q.ie),
    .flag      (flag_q),
    .done      (seq_done),
    .busy      (seq_busy),
    .start_req (start_req),
    .abort     (abort),
    .launch    (seq_launch),
    .conv_chan (conv_chan),
    .conv_ref  (conv_ref),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata)
);

// File: tb/sar_ctrl_top_tb_top.sv
module sar_ctrl_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [9:0] sample_in = '0;
    logic       gie = 1'b0;
    logic       irq_ack = 1'b0;
    logic       irq;
    logic [3:0] conv_chan;
    logic [1:0] conv_ref;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic [1:0] addr;
        logic [7:0] exp;
        string      tag;
    } exp_t;
    exp_t sbq[$];

    sar_ctrl_top dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sample_in(sample_in), .gie(gie),
        .irq_ack(irq_ack), .irq(irq), .conv_chan(conv_chan), .conv_ref(conv_ref)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Scoreboard monitor: compares every strobed read against the queued item.
    always @(negedge clk) begin : monitor
        exp_t e;
        #2;
        if (bus_rd) begin
            if (sbq.size() == 0) begin
                chk("scoreboard underflow", 1, 0);
            end else begin
                e = sbq.pop_front();
                chk(e.tag, int'(bus_rdata), int'(e.exp));
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd_exp(input logic [1:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        sbq.push_back('{a, e, tag});
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Counts the cycles the busy bit reads one, sampled once per cycle.
    task automatic run_conv(output int n);
        n = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            bus_addr = 2'd1;
            #1;
            if (!bus_rdata[6]) break;
            n++;
        end
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        chk("watchdog expired", 1, 0);
        summary();
        $finish;
    end

    initial begin : stim
        int n;
        int t0;
        logic [7:0] d;

        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state
        rd_exp(2'd0, 8'h00, "R1 selection reset");
        rd_exp(2'd1, 8'h00, "R1 control reset");
        rd_exp(2'd2, 8'h00, "R1 result low reset");
        rd_exp(2'd3, 8'h00, "R1 result high reset");
        chk("R1 irq reset", int'(irq), 0);
        chk("R1 conv_chan reset", int'(conv_chan), 0);
        wr(2'd0, 8'h1F);
        rd_exp(2'd0, 8'h0F, "R1 bit4 reads zero");

        // R2/R3/R6: first conversion, divider select 0 (div 2)
        wr(2'd0, 8'h45);
        sample_in = 10'h2B5;
        wr(2'd1, 8'hC0);
        run_conv(n);
        chk("R2 first conversion 25 ticks x2", n, 50);
        chk("R8 channel latched", int'(conv_chan), 5);
        chk("R8 reference latched", int'(conv_ref), 1);
        rd_exp(2'd1, 8'h90, "R5 flag set on completion");
        rd_exp(2'd2, 8'hB5, "R6 low byte right-justified");
        rd_exp(2'd3, 8'h02, "R6 high byte right-justified");

        // R4/R5: start bit zero has no effect, flag write-one-clear
        wr(2'd1, 8'h90);
        rd_exp(2'd1, 8'h80, "R4 start zero ignored, R5 flag cleared");

        // R2/R3: later conversion, divider select 2 (div 4)
        sample_in = 10'h155;
        wr(2'd1, 8'hC2);
        run_conv(n);
        chk("R3 later conversion 13 ticks x4", n, 52);
        rd_exp(2'd2, 8'h55, "R6 low byte");
        rd_exp(2'd3, 8'h01, "R6 high byte");

        // R8: selection written mid-conversion is held off
        wr(2'd1, 8'h90);
        wr(2'd1, 8'hC0);
        wr(2'd0, 8'hC9);
        chk("R8 channel held mid-conversion", int'(conv_chan), 5);
        chk("R8 reference held mid-conversion", int'(conv_ref), 1);
        rd_exp(2'd0, 8'hC9, "R8 selection reads new value");
        run_conv(n);
        chk("R8 channel held after completion", int'(conv_chan), 5);
        sample_in = 10'h2B5;
        wr(2'd1, 8'hD0);
        chk("R8 new channel at next start", int'(conv_chan), 9);
        chk("R8 new reference at next start", int'(conv_ref), 3);
        run_conv(n);

        // R4/R9: busy readback, restart ignored, justification mid-conversion
        wr(2'd1, 8'hD0);
        t0 = cyc;
        rd_exp(2'd1, 8'hC0, "R4 busy reads one");
        wr(2'd0, 8'hE9);
        rd_exp(2'd2, 8'h40, "R9 left low byte mid-conversion");
        rd_exp(2'd3, 8'hAD, "R9 left high byte mid-conversion");
        wr(2'd1, 8'hC0);
        run_conv(n);
        chk("R4 start while running ignored", cyc - t0, 26);
        wr(2'd0, 8'hC9);

        // R7/R5: interrupt gating and acknowledge
        wr(2'd1, 8'h88);
        #1 chk("R7 irq low without gie", int'(irq), 0);
        gie = 1'b1;
        #1 chk("R7 irq high", int'(irq), 1);
        @(negedge clk) irq_ack = 1'b1;
        @(posedge clk);
        #1 irq_ack = 1'b0;
        chk("R7 irq low after acknowledge", int'(irq), 0);
        rd_exp(2'd1, 8'h88, "R5 acknowledge clears flag");
        gie = 1'b0;

        // R10: abort by disabling
        sample_in = 10'h3FF;
        wr(2'd1, 8'hC0);
        repeat (5) @(negedge clk);
        wr(2'd1, 8'h00);
        rd_exp(2'd1, 8'h00, "R10 aborted, idle");
        repeat (60) @(negedge clk);
        rd_exp(2'd1, 8'h00, "R10 flag stays clear");
        rd_exp(2'd2, 8'hB5, "R10 result low unchanged");
        rd_exp(2'd3, 8'h02, "R10 result high unchanged");
        wr(2'd1, 8'hC0);
        run_conv(n);
        chk("R2 first conversion again after re-enable", n, 50);

        // R11: free-running chain and orderly stop
        wr(2'd1, 8'h90);
        sample_in = 10'h0F0;
        wr(2'd1, 8'hE0);
        t0 = cyc;
        wait_until(t0 + 60);
        sample_in = 10'h10F;
        wait_until(t0 + 80);
        rd_exp(2'd2, 8'h0F, "R11 chain updates low");
        rd_exp(2'd3, 8'h01, "R11 chain updates high");
        wr(2'd1, 8'h80);
        sample_in = 10'h2C3;
        rd_exp(2'd1, 8'hD0, "R11 current conversion still running");
        wait_until(t0 + 110);
        peek(2'd1, d);
        chk("R11 idle after chain stops", int'(d[6]), 0);
        rd_exp(2'd2, 8'hC3, "R11 last conversion completes low");
        rd_exp(2'd3, 8'h02, "R11 last conversion completes high");
        sample_in = 10'h000;
        wait_until(t0 + 160);
        rd_exp(2'd2, 8'hC3, "R11 no further conversions");
        rd_exp(2'd3, 8'h02, "R11 no further conversions high");

        // R12: high byte held between the two reads
        wr(2'd1, 8'h90);
        rd_exp(2'd2, 8'hC3, "R12 low read");
        sample_in = 10'h155;
        wr(2'd1, 8'hC0);
        run_conv(n);
        rd_exp(2'd3, 8'h02, "R12 high byte held");
        rd_exp(2'd3, 8'h01, "R12 high byte live after release");
        rd_exp(2'd2, 8'h55, "R12 low byte new result");

        repeat (5) @(negedge clk);
        chk("scoreboard drained", sbq.size(), 0);
        summary();
        $finish;
    end

endmodule